// File: doc/BRIEF.md
# Selector DMA Channel Programming Front End

This block is the register-loading side of a byte-wide selector DMA channel. A processor talks to it one byte at a time through a device I/O port. Data bytes written to the port are shifted through an end-address register and on into a start-address register. Data reads walk back through the start address one byte at a time. Command bytes start or stop the channel. Status reads report whether the channel is busy, or pass on the status of the device attached to it.

When a start command arrives, the two addresses are normalised for the transfer engine. This covers the bank bits, an even start address, and an end address raised to the top of the address space when it does not lie above the start. A parameter fixes the addressing variant: plain 16-bit, 16-bit plus a 2-bit bank (18-bit), or wide (up to 20 bits). The memory transfer engine and the devices themselves sit outside this block. The block only holds the number of the device last attached, and takes that device's status from its inputs.

Top module: `dma_prog_front`

## Requirements
- R1: After reset, the start and end addresses are 0, no command bit is held (go_o=0, rd_dir_o=0), the write count is 0, dev_num_o is 0 and the read pointer is 1, so rd_data_o shows start-address bits 15:8.
- R2: In 16-bit and 18-bit modes, a data write (op_i=0) does two things. The start address becomes ((start<<8) | (end>>8)) truncated to 16 bits, and the end address becomes ((end<<8) | byte) truncated to 16 bits. Once 4 writes have been taken, further writes leave both addresses unchanged until a STOP.
- R3: In wide mode, up to 6 writes are taken. Writes 1 to 5 set start = (start<<8) | end[15:8] and end = {end[7:0], byte}. Write 6 sets end = (end<<8) | byte. Both values are truncated to AW bits. A 7th or later write changes nothing.
- R4: rd_data_o always shows start-address byte p, meaning bits 8p+7:8p, where p is the read pointer. A data read (op_i=1) moves p as follows: if p is 0, it reloads to 2 when the held extended-read bit is set in wide mode, and to 1 otherwise; any other p is decremented.
- R5: The command byte (op_i=2) uses these bits: bit 6 extended read, bit 5 read direction, bit 4 GO, bit 3 STOP, bit 2 channel-status select, bits 1:0 bank. When STOP and GO are both set, STOP wins. A command with neither bit set leaves the held command unchanged.
- R6: A STOP does four things. The held command keeps only bits 6 and 2, so GO and the read direction are cleared. irq_clr_o is high during the command cycle. The read pointer goes to 2 if the new command has extended read in wide mode, and to 1 otherwise. The write count goes to 0.
- R7: A GO does three things in order. First, the held command becomes the byte masked to bits 6, 5, 4 and 2. Second, if 4 or fewer writes were taken, both addresses are cut to 16 bits and ORed with bank<<16. Third, start bit 0 is cleared.
- R8: On GO, after the R7 steps, if end <= start, the end address is ORed with all ones: 0xFFFF in the 16-bit and 18-bit modes, and all AW bits in wide mode.
- R9: In the 16-bit and 18-bit modes, bits 6 and 2 of an incoming command are dropped. The bank field is applied only in 18-bit mode; the 16-bit and wide modes treat it as 0.
- R10: status_o is 0x08 while GO is held. Otherwise it is 0x00 while channel-status select is held. Otherwise it is dev_sta_i with bit 3 cleared when dev_present_i is 1, and 0x04 when dev_present_i is 0. A status read (op_i=3) changes no state.
- R11: dev_we_i loads dev_i into dev_num_o on the next edge, whatever CPU operation is carried out in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A CPU port operation is carried out this cycle |
| op_i | input | 2 | 0 data write, 1 data read, 2 command, 3 status read |
| data_i | input | 8 | Write data or command byte |
| dev_we_i | input | 1 | Attached device records its number |
| dev_i | input | 8 | Device number to record |
| dev_sta_i | input | 8 | Status of the recorded device |
| dev_present_i | input | 1 | The recorded device exists |
| rd_data_o | output | 8 | Start-address byte under the read pointer |
| status_o | output | 8 | Channel status byte |
| irq_clr_o | output | 1 | Clear the channel interrupt request (STOP in this cycle) |
| go_o | output | 1 | Channel started |
| rd_dir_o | output | 1 | Transfer direction is read |
| start_addr_o | output | AW | Start address |
| end_addr_o | output | AW | End address |
| dev_num_o | output | 8 | Recorded device number |

## Verification
The device-number latch runs in the same cycle as a CPU command. The case of interest is a STOP or GO issued while dev_we_i records a new device. The bench drives dev_we_i together with command bytes, and also together with reads and writes. It then checks that the command effects and the new dev_num_o both appear one edge later, and that status_o follows the new device once GO has been dropped. All three address modes run side by side on the same stimulus against a behavioural model, so every byte shift, pointer step and GO normalisation is compared on every clock.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;
  typedef enum logic [1:0] {
    OP_WDATA = 2'd0,
    OP_RDATA = 2'd1,
    OP_CMD   = 2'd2,
    OP_STAT  = 2'd3
  } op_e;

  localparam int MODE_A16  = 0;
  localparam int MODE_A18  = 1;
  localparam int MODE_WIDE = 2;

  localparam int BIT_EXT   = 6;
  localparam int BIT_RDIR  = 5;
  localparam int BIT_GO    = 4;
  localparam int BIT_STOP  = 3;
  localparam int BIT_CHSTA = 2;

  localparam logic [7:0] KEEP_STOP = 8'h44;
  localparam logic [7:0] KEEP_GO   = 8'h74;
  localparam logic [7:0] STA_BUSY  = 8'h08;
  localparam logic [7:0] STA_NODEV = 8'h04;
endpackage

// File: rtl/dma_cmd_unit.sv
module dma_cmd_unit
  import dma_prog_pkg::*;
#(
  parameter int MODE = MODE_WIDE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] data_i,
  input  logic [7:0] dev_sta_i,
  input  logic       dev_present_i,
  output logic [7:0] cmd_o,
  output logic       stop_fire_o,
  output logic       go_fire_o,
  output logic [1:0] bank_o,
  output logic       exr_now_o,
  output logic       exr_next_o,
  output logic [7:0] status_o
);
  localparam bit WIDE = (MODE == MODE_WIDE);

  logic [7:0] cmd_q, cmd_d, dat_eff;

  generate
    if (WIDE) begin : g_wide
      assign dat_eff = data_i;
    end else begin : g_narrow
      assign dat_eff = data_i & ~KEEP_STOP;  // strip ext-read and chan-status
    end
    if (MODE == MODE_A18) begin : g_bank
      assign bank_o = dat_eff[1:0];
    end else begin : g_nobank
      assign bank_o = 2'b00;
    end
  endgenerate

  assign stop_fire_o = cmd_we_i & dat_eff[BIT_STOP];
  assign go_fire_o   = cmd_we_i & ~dat_eff[BIT_STOP] & dat_eff[BIT_GO];

  always_comb begin
    cmd_d = cmd_q;
    if (stop_fire_o)    cmd_d = dat_eff & KEEP_STOP;
    else if (go_fire_o) cmd_d = dat_eff & KEEP_GO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd_d;
  end

  assign cmd_o      = cmd_q;
  assign exr_now_o  = WIDE & cmd_q[BIT_EXT];
  assign exr_next_o = WIDE & cmd_d[BIT_EXT];

  always_comb begin
    if (cmd_q[BIT_GO])         status_o = STA_BUSY;
    else if (cmd_q[BIT_CHSTA]) status_o = 8'h00;
    else if (dev_present_i)    status_o = dev_sta_i & ~STA_BUSY;
    else                       status_o = STA_NODEV;
  end

  AST_STOP_CLEARS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_fire_o |=> !cmd_q[BIT_GO] && !cmd_q[BIT_RDIR]);  // R6
  AST_BUSY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q[BIT_GO] |-> status_o == STA_BUSY);  // R10
  AST_NARROW_STRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WIDE && cmd_we_i) |=> cmd_q[BIT_EXT] == 1'b0 && cmd_q[BIT_CHSTA] == 1'b0);  // R9
endmodule

// File: rtl/dma_addr_shift.sv
module dma_addr_shift
  import dma_prog_pkg::*;
#(
  parameter int MODE = MODE_WIDE,
  parameter int AW   = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_fire_i,
  input  logic [7:0]    data_i,
  input  logic          go_fire_i,
  input  logic          stop_fire_i,
  input  logic [1:0]    bank_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o
);
  localparam bit WIDE = (MODE == MODE_WIDE);
  localparam int WLIM = WIDE ? 6 : 4;
  localparam int CW   = $clog2(WLIM + 1);
  localparam logic [AW-1:0] M16  = AW'(17'h0FFFF);
  localparam logic [AW-1:0] FILL = WIDE ? {AW{1'b1}} : M16;

  logic [AW-1:0] sa_q, ea_q, sa_d, ea_d, bank_ext;
  logic [CW-1:0] wdc_q, wdc_d;

  assign bank_ext = AW'(bank_i) << 16;

  always_comb begin
    sa_d  = sa_q;
    ea_d  = ea_q;
    wdc_d = wdc_q;
    if (stop_fire_i) begin
      wdc_d = '0;
    end else if (go_fire_i) begin
      if (wdc_q <= CW'(4)) begin
        sa_d = (sa_q & M16) | bank_ext;
        ea_d = (ea_q & M16) | bank_ext;
      end
      sa_d[0] = 1'b0;
      if (ea_d <= sa_d) ea_d = ea_d | FILL;
    end else if (wr_fire_i && wdc_q < CW'(WLIM)) begin
      if (!WIDE) begin
        sa_d = ((sa_q << 8) | (ea_q >> 8)) & M16;
        ea_d = ((ea_q << 8) | AW'(data_i)) & M16;
      end else if (wdc_q != CW'(5)) begin
        sa_d = (sa_q << 8) | AW'(ea_q[15:8]);
        ea_d = AW'({ea_q[7:0], data_i});
      end else begin
        ea_d = (ea_q << 8) | AW'(data_i);
      end
      wdc_d = wdc_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q  <= '0;
      ea_q  <= '0;
      wdc_q <= '0;
    end else begin
      sa_q  <= sa_d;
      ea_q  <= ea_d;
      wdc_q <= wdc_d;
    end
  end

  assign start_o = sa_q;
  assign end_o   = ea_q;

  AST_WCOUNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdc_q <= CW'(WLIM));  // R3
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_i && wdc_q == CW'(WLIM)) |=> $stable(sa_q) && $stable(ea_q));  // R2
  AST_GO_EVEN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_fire_i |=> sa_q[0] == 1'b0);  // R7
  AST_GO_END_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_fire_i |=> ea_q > sa_q);  // R8
endmodule

// File: rtl/dma_rdback.sv
module dma_rdback #(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_fire_i,
  input  logic          stop_fire_i,
  input  logic          exr_now_i,
  input  logic          exr_next_i,
  input  logic [AW-1:0] start_i,
  output logic [7:0]    rd_byte_o
);
  localparam int PW = 32;

  logic [1:0]    ptr_q, ptr_d;
  logic [PW-1:0] sa_pad;

  always_comb begin
    ptr_d = ptr_q;
    if (stop_fire_i)    ptr_d = exr_next_i ? 2'd2 : 2'd1;
    else if (rd_fire_i) ptr_d = (ptr_q == 2'd0) ? (exr_now_i ? 2'd2 : 2'd1) : ptr_q - 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= 2'd1;
    else         ptr_q <= ptr_d;
  end

  assign sa_pad    = PW'(start_i);
  assign rd_byte_o = sa_pad[{ptr_q, 3'b000} +: 8];

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= 2'd2);  // R4
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire_i && !stop_fire_i && ptr_q != 2'd0) |=> ptr_q == $past(ptr_q) - 2'd1);  // R4
endmodule

// File: rtl/dma_prog_front.sv
module dma_prog_front
  import dma_prog_pkg::*;
#(
  parameter int MODE = MODE_WIDE,
  parameter int AW   = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [1:0]    op_i,
  input  logic [7:0]    data_i,
  input  logic          dev_we_i,
  input  logic [7:0]    dev_i,
  input  logic [7:0]    dev_sta_i,
  input  logic          dev_present_i,
  output logic [7:0]    rd_data_o,
  output logic [7:0]    status_o,
  output logic          irq_clr_o,
  output logic          go_o,
  output logic          rd_dir_o,
  output logic [AW-1:0] start_addr_o,
  output logic [AW-1:0] end_addr_o,
  output logic [7:0]    dev_num_o
);
  op_e           op;
  logic          wr_fire, rd_fire, cmd_we;
  logic          stop_fire, go_fire, exr_now, exr_next;
  logic [1:0]    bank;
  logic [7:0]    cmd;
  logic [AW-1:0] sa, ea;
  logic [7:0]    dev_q;

  assign op      = op_e'(op_i);
  assign wr_fire = op_valid_i && op == OP_WDATA;
  assign rd_fire = op_valid_i && op == OP_RDATA;
  assign cmd_we  = op_valid_i && op == OP_CMD;

  dma_cmd_unit #(.MODE(MODE)) i_cmd (
    .clk_i, .rst_ni, .cmd_we_i(cmd_we), .data_i, .dev_sta_i, .dev_present_i,
    .cmd_o(cmd), .stop_fire_o(stop_fire), .go_fire_o(go_fire), .bank_o(bank),
    .exr_now_o(exr_now), .exr_next_o(exr_next), .status_o
  );

  dma_addr_shift #(.MODE(MODE), .AW(AW)) i_addr (
    .clk_i, .rst_ni, .wr_fire_i(wr_fire), .data_i, .go_fire_i(go_fire),
    .stop_fire_i(stop_fire), .bank_i(bank), .start_o(sa), .end_o(ea)
  );

  dma_rdback #(.AW(AW)) i_rdb (
    .clk_i, .rst_ni, .rd_fire_i(rd_fire), .stop_fire_i(stop_fire),
    .exr_now_i(exr_now), .exr_next_i(exr_next), .start_i(sa), .rd_byte_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dev_q <= '0;
    else if (dev_we_i) dev_q <= dev_i;
  end

  assign irq_clr_o    = stop_fire;
  assign go_o         = cmd[BIT_GO];
  assign rd_dir_o     = cmd[BIT_RDIR];
  assign start_addr_o = sa;
  assign end_addr_o   = ea;
  assign dev_num_o    = dev_q;

  AST_DEV_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_we_i |=> dev_num_o == $past(dev_i));  // R11
  AST_STAT_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_STAT) |=> $stable(start_addr_o) && $stable(end_addr_o) && $stable(go_o));  // R10
endmodule

// File: tb/test_dma_prog_front.sv
module test_dma_prog_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] data = 8'h00;
  logic dev_we = 1'b0;
  logic [7:0] dev = 8'h00;
  logic [7:0] dev_sta = 8'h00;
  logic dev_present = 1'b0;

  logic [7:0]    rdb [3];
  logic [7:0]    sta [3];
  logic          irqc [3];
  logic          go [3];
  logic          rdir [3];
  logic [AW-1:0] sa [3];
  logic [AW-1:0] ea [3];
  logic [7:0]    dnum [3];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_sa [3], m_ea [3], m_cmd [3], m_wdc [3], m_ptr [3];
  int m_dev;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prog_front #(.MODE(2), .AW(AW)) i_dma_prog_front (
    .clk_i(clk), .rst_ni, .op_valid_i(op_valid), .op_i(op), .data_i(data),
    .dev_we_i(dev_we), .dev_i(dev), .dev_sta_i(dev_sta), .dev_present_i(dev_present),
    .rd_data_o(rdb[2]), .status_o(sta[2]), .irq_clr_o(irqc[2]), .go_o(go[2]),
    .rd_dir_o(rdir[2]), .start_addr_o(sa[2]), .end_addr_o(ea[2]), .dev_num_o(dnum[2]));
  dma_prog_front #(.MODE(0), .AW(AW)) i_dma_prog_front_a16 (
    .clk_i(clk), .rst_ni, .op_valid_i(op_valid), .op_i(op), .data_i(data),
    .dev_we_i(dev_we), .dev_i(dev), .dev_sta_i(dev_sta), .dev_present_i(dev_present),
    .rd_data_o(rdb[0]), .status_o(sta[0]), .irq_clr_o(irqc[0]), .go_o(go[0]),
    .rd_dir_o(rdir[0]), .start_addr_o(sa[0]), .end_addr_o(ea[0]), .dev_num_o(dnum[0]));
  dma_prog_front #(.MODE(1), .AW(AW)) i_dma_prog_front_a18 (
    .clk_i(clk), .rst_ni, .op_valid_i(op_valid), .op_i(op), .data_i(data),
    .dev_we_i(dev_we), .dev_i(dev), .dev_sta_i(dev_sta), .dev_present_i(dev_present),
    .rd_data_o(rdb[1]), .status_o(sta[1]), .irq_clr_o(irqc[1]), .go_o(go[1]),
    .rd_dir_o(rdir[1]), .start_addr_o(sa[1]), .end_addr_o(ea[1]), .dev_num_o(dnum[1]));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_exr(int md, int c);
    return (md == 2 && (c & 'h40) != 0) ? 1 : 0;
  endfunction

  task automatic model_reset();
    for (int md = 0; md < 3; md++) begin
      m_sa[md] = 0; m_ea[md] = 0; m_cmd[md] = 0; m_wdc[md] = 0; m_ptr[md] = 1;
    end
    m_dev = 0;
  endtask

  // compare all outputs of all three modes against the model, then advance the model
  task automatic cycle(bit v, int o, int d, bit dw = 0, int dv = 0);
    @(negedge clk);
    op_valid = v; op = 2'(o); data = 8'(d); dev_we = dw; dev = 8'(dv);
    #1;
    for (int md = 0; md < 3; md++) begin
      int eff, bank, exp_sta, lim, fill;
      eff = (md == 2) ? d : (d & ~'h44);
      if ((m_cmd[md] & 'h10) != 0)      exp_sta = 'h08;
      else if ((m_cmd[md] & 'h04) != 0) exp_sta = 0;
      else if (dev_present)             exp_sta = dev_sta & ~'h08;
      else                              exp_sta = 'h04;
      chk("R4", "rd_data", rdb[md], (m_sa[md] >> (8 * m_ptr[md])) & 'hFF);
      chk("R10", "status", sta[md], exp_sta);
      chk("R6", "irq_clr", irqc[md], (v && o == 2 && (eff & 'h08) != 0) ? 1 : 0);
      chk("R7", "go", go[md], (m_cmd[md] >> 4) & 1);
      chk("R5", "rd_dir", rdir[md], (m_cmd[md] >> 5) & 1);
      chk("R2", "start", sa[md], m_sa[md]);
      chk("R3", "end", ea[md], m_ea[md]);
      chk("R11", "dev_num", dnum[md], m_dev);
      bank = (md == 1) ? ((eff & 3) << 16) : 0;
      lim  = (md == 2) ? 6 : 4;
      fill = (md == 2) ? 'hFFFFF : 'hFFFF;
      if (v && o == 0 && m_wdc[md] < lim) begin
        if (md != 2) begin
          m_sa[md] = ((m_sa[md] << 8) | (m_ea[md] >> 8)) & 'hFFFF;
          m_ea[md] = ((m_ea[md] << 8) | d) & 'hFFFF;
        end else if (m_wdc[md] != 5) begin
          m_sa[md] = ((m_sa[md] << 8) | ((m_ea[md] >> 8) & 'hFF)) & 'hFFFFF;
          m_ea[md] = ((m_ea[md] & 'hFF) << 8) | d;
        end else begin
          m_ea[md] = ((m_ea[md] << 8) | d) & 'hFFFFF;
        end
        m_wdc[md]++;
      end else if (v && o == 1) begin
        if (m_ptr[md] == 0) m_ptr[md] = m_exr(md, m_cmd[md]) ? 2 : 1;
        else m_ptr[md]--;
      end else if (v && o == 2) begin
        if ((eff & 'h08) != 0) begin
          m_cmd[md] = eff & 'h44;
          m_ptr[md] = m_exr(md, m_cmd[md]) ? 2 : 1;
          m_wdc[md] = 0;
        end else if ((eff & 'h10) != 0) begin
          m_cmd[md] = eff & 'h74;
          if (m_wdc[md] <= 4) begin
            m_sa[md] = (m_sa[md] & 'hFFFF) | bank;
            m_ea[md] = (m_ea[md] & 'hFFFF) | bank;
          end
          m_sa[md] = m_sa[md] & ~1;
          if (m_ea[md] <= m_sa[md]) m_ea[md] = m_ea[md] | fill;
        end
      end
    end
    if (dw) m_dev = dv;
  endtask

  task automatic idle();
    cycle(0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R1 reset state
    #1;
    for (int md = 0; md < 3; md++) begin
      chk("R1", "start after reset", sa[md], 0);
      chk("R1", "end after reset", ea[md], 0);
      chk("R1", "go after reset", go[md], 0);
      chk("R1", "dev after reset", dnum[md], 0);
    end
    idle();
    // load 7 bytes; narrow modes take 4, wide takes 6
    cycle(1, 0, 'h12); cycle(1, 0, 'h34); cycle(1, 0, 'h56); cycle(1, 0, 'h78);
    idle();
    chk("R1", "ptr starts at 1", rdb[2], 'h12);
    chk("R2", "a16 start after 4", sa[0], 'h1234);
    chk("R2", "a16 end after 4", ea[0], 'h5678);
    cycle(1, 1, 0);
    cycle(1, 1, 0);
    cycle(1, 1, 0);
    cycle(1, 0, 'h9A); cycle(1, 0, 'hBC); cycle(1, 0, 'hDE);
    idle();
    chk("R3", "wide start after 6", sa[2], 'h23456);
    chk("R3", "wide end after 6", ea[2], 'h89ABC);
    chk("R2", "a16 writes 5+ ignored", ea[0], 'h5678);
    // GO with a device recorded in the same cycle
    cycle(1, 2, 'h10, 1, 'h5A);
    cycle(1, 3, 0);
    chk("R10", "busy while go", sta[2], 'h08);
    chk("R11", "dev latched beside GO", dnum[0], 'h5A);
    cycle(1, 0, 'h11);
    // STOP with ext-read, device change in same cycle
    cycle(1, 2, 'h48, 1, 'hA5);
    idle();
    chk("R6", "go cleared by stop", go[2], 0);
    chk("R4", "wide ext ptr=2", rdb[2], 'h02);
    chk("R9", "a16 ext stripped ptr=1", rdb[0], 'h12);
    for (int i = 0; i < 5; i++) cycle(1, 1, 0);
    dev_present = 1'b1; dev_sta = 8'hFF;
    idle();
    chk("R10", "device status busy cleared", sta[2], 'hF7);
    dev_present = 1'b0;
    idle();
    chk("R10", "no device", sta[2], 'h04);
    cycle(1, 2, 'h0C);
    idle();
    chk("R10", "chan status selected", sta[2], 'h00);
    chk("R9", "a16 chan status stripped", sta[0], 'h04);
    // wrap: start 0x0010, end 0x0008, GO with bank 2
    cycle(1, 0, 'h00); cycle(1, 0, 'h10); cycle(1, 0, 'h00); cycle(1, 0, 'h08);
    cycle(1, 2, 'h12);
    idle();
    chk("R8", "a16 wrap end", ea[0], 'hFFFF);
    chk("R9", "a18 bank start", sa[1], 'h20010);
    chk("R8", "a18 wrap end keeps bank", ea[1], 'h2FFFF);
    chk("R8", "wide wrap end", ea[2], 'hFFFFF);
    // STOP and GO together: STOP wins
    cycle(1, 2, 'h18);
    idle();
    chk("R5", "stop beats go", go[2], 0);
    // odd start, read direction, command with neither bit
    cycle(1, 0, 'h01); cycle(1, 0, 'h23); cycle(1, 0, 'h45); cycle(1, 0, 'h67);
    cycle(1, 2, 'h31, 1, 'h3C);
    cycle(1, 2, 'h01);
    idle();
    chk("R7", "start bit0 cleared", sa[0], 'h0122);
    chk("R5", "read dir held", rdir[2], 1);
    cycle(1, 2, 'h08);
    for (int i = 0; i < 4; i++) cycle(1, 0, 8'(i * 37 + 5), i[0], i);
    cycle(1, 2, 'h50);
    cycle(1, 3, 0, 1, 'h77);
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule